// File: doc/BRIEF.md
# Sequential Restoring Floating-Point Divider

This block divides one positive, normalized single-precision value by another over a fixed number of clock cycles. When `start` is seen while the unit is idle, both operand words are captured. The exponents are separated from the fractions, and each fraction regains its implicit leading one. The dividend significand is pre-aligned by at most one position so that the quotient's leading bit always lands in the same place. A restoring shift-and-subtract loop then produces one quotient bit per clock.

After the loop, one more cycle rounds the quotient to nearest-even, or truncates it when rounding is disabled at build time, and assembles the result word. `done` then pulses for one cycle, and `result` holds that value until the next operation finishes. The latency is the same for every pair of operands. Operand signs are assumed to be zero. Zero, infinity, NaN, exponent overflow and underflow, and a rounding carry out of the significand are not handled.

Top module: `fdiv_seq`

## Requirements
- R1: While `rst` is high, and after it is released, `done` is 0 and `result` is 0 until the first operation completes.
- R2: Each operand's significand is `{1, word[22:0]}`. The exponent field of `word[30:23]` contributes ea - eb + 127. Equal fractions and a 1.0/1.0 input give `0x3F800000`, and 6.0/3.0 gives `0x40000000`.
- R3: When the dividend significand is smaller than the divisor significand, the dividend significand is doubled once and the result exponent is one lower (1.0/1.5 gives exponent field 126).
- R4: Exactly 25 quotient bits q[24:0] are formed, where q = floor(A*2^24 / sb), A is the aligned dividend significand and sb is the divisor significand. With rounding disabled, the result fraction is the low 23 bits of q >> 1.
- R5: With rounding enabled, the fraction is the low 23 bits of (q >> 1) + (q[0] AND (sticky OR q[1])), where sticky is 1 when the final remainder is nonzero.
- R6: A quotient that is exact (remainder zero, with q[0] clear) is never incremented by rounding.
- R7: `done` is high for exactly one cycle. It rises on the 27th rising edge counted from the edge that sampled the accepted `start`, with that edge counted as the first, for every operand pair.
- R8: `start` pulses and operand changes while an operation is in progress do not alter that operation's result or its completion time.
- R9: Between completions, `result` keeps its value whatever the inputs do.
- R10: The result word has sign bit 31 equal to 0. Its exponent field [30:23] is the low 8 bits of the computed exponent, so 250 - 2 + 127 = 375 packs as 0x77.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only when idle |
| op_a | input | 32 | Dividend word (sign 0, normalized) |
| op_b | input | 32 | Divisor word (sign 0, normalized) |
| done | output | 1 | One-cycle pulse when `result` has been updated |
| result | output | 32 | Quotient word, held until the next completion |

## Verification
A sweep pairs 16 dividend fractions with 16 divisor fractions, among them all-zero and all-one fractions, across a spread of exponents. This exercises both sides of the pre-alignment decision and every combination of round bit, odd bit and sticky bit. Each result is compared with an exact integer long division done in the bench, both for the rounding build and for a truncating build driven with the same inputs. Any disagreement between the two builds on a given input isolates the rounding increment. Directed cases cover exact quotients, the 1.0/1.5 case that needs alignment and rounds up, and exponent wrap. A restart attempted during a busy operation shows whether the operands are really captured once.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int FD_EXP_W  = 8;
    localparam int FD_MAN_W  = 23;
    localparam int FD_WORD_W = 1 + FD_EXP_W + FD_MAN_W;
    localparam int FD_SIG_W  = FD_MAN_W + 1;
    localparam int FD_QBITS  = FD_MAN_W + 2;
    localparam int FD_QREG_W = FD_QBITS - 1;
    localparam int FD_REM_W  = FD_SIG_W + 2;
    localparam int FD_CNT_W  = $clog2(FD_QBITS);
    localparam int FD_BIAS   = (1 << (FD_EXP_W - 1)) - 1;

    typedef enum logic [1:0] {
        FD_IDLE = 2'd0,
        FD_RUN  = 2'd1,
        FD_PACK = 2'd2
    } fd_state_e;

    typedef struct packed {
        logic [FD_EXP_W-1:0] exp;
        logic [FD_REM_W-1:0] rem;
        logic [FD_SIG_W-1:0] dvs;
    } fd_work_t;

    function automatic logic [FD_SIG_W-1:0] fd_restore(input logic [FD_MAN_W-1:0] frac);
        return {1'b1, frac};
    endfunction

    function automatic logic [FD_EXP_W-1:0] fd_exp_of(input logic [FD_WORD_W-2:0] mag);
        return mag[FD_WORD_W-2:FD_MAN_W];
    endfunction

endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack
    import fdiv_pkg::*;
(
    input  logic [FD_WORD_W-2:0] mag_a,
    input  logic [FD_WORD_W-2:0] mag_b,
    output fd_work_t             init
);
    logic [FD_SIG_W-1:0] sig_a;
    logic [FD_SIG_W-1:0] sig_b;
    logic [FD_EXP_W-1:0] exp_raw;
    logic                low_dividend;

    always_comb begin
        sig_a        = fd_restore(mag_a[FD_MAN_W-1:0]);
        sig_b        = fd_restore(mag_b[FD_MAN_W-1:0]);
        exp_raw      = fd_exp_of(mag_a) - fd_exp_of(mag_b) + FD_EXP_W'(FD_BIAS);
        low_dividend = (sig_a < sig_b);
        init.dvs     = sig_b;
        if (low_dividend) begin
            init.rem = {1'b0, sig_a, 1'b0};
            init.exp = exp_raw - FD_EXP_W'(1);
        end else begin
            init.rem = {2'b00, sig_a};
            init.exp = exp_raw;
        end
    end
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step
    import fdiv_pkg::*;
(
    input  logic [FD_REM_W-1:0] rem,
    input  logic [FD_SIG_W-1:0] dvs,
    output logic [FD_REM_W-1:0] rem_next,
    output logic                qbit
);
    logic [FD_REM_W-1:0] dvs_ext;
    logic [FD_REM_W-1:0] trial;
    logic [FD_REM_W-1:0] kept;

    always_comb begin
        dvs_ext  = {2'b00, dvs};
        trial    = rem - dvs_ext;
        qbit     = (rem >= dvs_ext);
        kept     = qbit ? trial : rem;
        rem_next = {kept[FD_REM_W-2:0], 1'b0};
    end
endmodule

// File: rtl/fdiv_round_pack.sv
module fdiv_round_pack
    import fdiv_pkg::*;
#(
    parameter bit ROUND_EN = 1'b1
) (
    input  logic [FD_EXP_W-1:0]  exp,
    input  logic [FD_QREG_W-1:0] quo,
    input  logic [FD_REM_W-1:0]  rem,
    output logic [FD_WORD_W-1:0] word
);
    logic                sticky;
    logic                rnd_bit;
    logic                odd_bit;
    logic                bump;
    logic [FD_MAN_W-1:0] frac;

    always_comb begin
        sticky  = |rem;
        rnd_bit = quo[0];
        odd_bit = quo[1];
        bump    = ROUND_EN ? (rnd_bit & (sticky | odd_bit)) : 1'b0;
        frac    = quo[FD_MAN_W:1] + FD_MAN_W'(bump);
        word    = {1'b0, exp, frac};
    end
endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
    import fdiv_pkg::*;
#(
    parameter int NSTEP = FD_QBITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                load,
    output logic                step_en,
    output logic                pack_en,
    output logic                busy,
    output logic [FD_CNT_W-1:0] step_cnt
);
    localparam logic [FD_CNT_W-1:0] LAST = FD_CNT_W'(NSTEP - 1);

    fd_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FD_IDLE;
            step_cnt <= '0;
        end else begin
            case (state)
                FD_IDLE: begin
                    step_cnt <= '0;
                    if (start) state <= FD_RUN;
                end
                FD_RUN: begin
                    if (step_cnt == LAST) begin
                        state    <= FD_PACK;
                        step_cnt <= '0;
                    end else begin
                        step_cnt <= step_cnt + FD_CNT_W'(1);
                    end
                end
                FD_PACK: state <= FD_IDLE;
                default: state <= FD_IDLE;
            endcase
        end
    end

    always_comb begin
        load    = (state == FD_IDLE) && start;
        step_en = (state == FD_RUN);
        pack_en = (state == FD_PACK);
        busy    = (state != FD_IDLE);
    end
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
#(
    parameter bit ROUND_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [FD_WORD_W-1:0] op_a,
    input  logic [FD_WORD_W-1:0] op_b,
    output logic                 done,
    output logic [FD_WORD_W-1:0] result
);
    logic                 load;
    logic                 step_en;
    logic                 pack_en;
    logic                 busy;
    logic [FD_CNT_W-1:0]  step_cnt;
    fd_work_t             init;
    fd_work_t             work;
    logic [FD_QREG_W-1:0] quo;
    logic [FD_REM_W-1:0]  rem_next;
    logic                 qbit;
    logic [FD_WORD_W-1:0] packed_word;

    fdiv_ctrl #(.NSTEP(FD_QBITS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load     (load),
        .step_en  (step_en),
        .pack_en  (pack_en),
        .busy     (busy),
        .step_cnt (step_cnt)
    );

    fdiv_unpack u_unpack (
        .mag_a (op_a[FD_WORD_W-2:0]),
        .mag_b (op_b[FD_WORD_W-2:0]),
        .init  (init)
    );

    fdiv_step u_step (
        .rem      (work.rem),
        .dvs      (work.dvs),
        .rem_next (rem_next),
        .qbit     (qbit)
    );

    fdiv_round_pack #(.ROUND_EN(ROUND_EN)) u_pack (
        .exp  (work.exp),
        .quo  (quo),
        .rem  (work.rem),
        .word (packed_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            quo    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= pack_en;
            if (load) begin
                work <= init;
                quo  <= '0;
            end
            if (step_en) begin
                work.rem <= rem_next;
                quo      <= {quo[FD_QREG_W-2:0], qbit};
            end
            if (pack_en) result <= packed_word;
        end
    end
endmodule

// File: rtl/fdiv_seq_chk.sv
module fdiv_seq_chk
    import fdiv_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [FD_WORD_W-1:0] op_a,
    input logic [FD_WORD_W-1:0] op_b,
    input logic                 busy,
    input logic                 done,
    input logic [FD_WORD_W-1:0] result,
    input logic [FD_CNT_W-1:0]  step_cnt
);
    localparam int LAT   = FD_QBITS + 2;
    localparam int LAT_W = $clog2(LAT + 1) + 1;

    logic [LAT_W-1:0] lat_cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
            armed   <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (start && !busy)             lat_cnt <= LAT_W'(1);
            else if (lat_cnt == LAT_W'(LAT)) lat_cnt <= '0;
            else if (lat_cnt != '0)          lat_cnt <= lat_cnt + LAT_W'(1);
        end
    end

    AST_POSITIVE_OPS: assert property (@(posedge clk) disable iff (rst)
        start |-> (!op_a[FD_WORD_W-1] && !op_b[FD_WORD_W-1])); // R2
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(step_cnt) < FD_QBITS); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        (lat_cnt == LAT_W'(LAT)) |-> done); // R7
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LAT_W'(LAT))); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (armed && !done) |-> $stable(result)); // R9
    AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done |-> !result[FD_WORD_W-1]); // R10
endmodule

bind fdiv_seq fdiv_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_a     (op_a),
    .op_b     (op_b),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .step_cnt (step_cnt)
);

// File: tb/fdiv_seq_tb.sv
module fdiv_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        done;
    logic        done_t;
    logic [31:0] result;
    logic [31:0] result_t;
    int          checks = 0;
    int          failures = 0;

    always #10 clk = ~clk;

    fdiv_seq #(.ROUND_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .done(done), .result(result)
    );

    fdiv_seq #(.ROUND_EN(1'b0)) u_dut_trunc (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .done(done_t), .result(result_t)
    );

    function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b, input bit rnd);
        logic [63:0] sa, sb, num, q, rm, fq;
        int          e;
        sa = {40'd0, 1'b1, a[22:0]};
        sb = {40'd0, 1'b1, b[22:0]};
        e  = int'(a[30:23]) - int'(b[30:23]) + 127;
        if (sa < sb) begin
            sa = sa * 2;
            e  = e - 1;
        end
        num = sa << 24;
        q   = num / sb;
        rm  = num % sb;
        fq  = q >> 1;
        if (rnd && q[0] && ((rm != 0) || q[1])) fq = fq + 1;
        return {1'b0, e[7:0], fq[22:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // launches and waits; checks done timing (R7) and both results
    task automatic run_div(input logic [31:0] a, input logic [31:0] b, input string req);
        launch(a, b);
        repeat (25) @(negedge clk);
        check("R7 done early", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R7 done rise", {30'd0, done, done_t}, 32'd3);
        check({req, " R5 rounded"}, result, ref_div(a, b, 1'b1));
        check({req, " R4 truncated"}, result_t, ref_div(a, b, 1'b0));
        @(negedge clk);
        check("R7 done fall", {30'd0, done, done_t}, 32'd0);
    endtask

    function automatic logic [22:0] mant(input int k);
        if (k == 0)  return 23'd0;
        if (k == 15) return 23'h7FFFFF;
        return 23'((k * 32'h002F1B3D) ^ (k << 17));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset done", {30'd0, done, done_t}, 32'd0);
        check("R1 reset result", result, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 after reset", result_t | result, 32'd0);

        // R2: exponent arithmetic with equal fractions
        run_div(32'h3F800000, 32'h3F800000, "R2 one");
        check("R2 one value", result, 32'h3F800000);
        run_div(32'h40C00000, 32'h40400000, "R2 six/three");
        check("R2 six/three value", result, 32'h40000000);
        check("R6 exact not bumped", result, result_t);

        // R3 + R5: alignment and round-up
        run_div(32'h3F800000, 32'h3FC00000, "R3 align");
        check("R3 align rounded", result, 32'h3F2AAAAB);
        check("R4 align truncated", result_t, 32'h3F2AAAAA);

        // R10: exponent wrap, sign clear
        run_div({1'b0, 8'd250, 23'd0}, {1'b0, 8'd2, 23'd0}, "R10 wrap");
        check("R10 wrap value", result, 32'h3B800000);

        // R8: restart attempts and operand churn while busy
        launch(32'h40490FDB, 32'h3FB504F3);
        repeat (5) @(negedge clk);
        op_a  = 32'h3F800000;
        op_b  = 32'h40000000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (19) @(negedge clk);
        check("R8 no early done", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R8 done on time", {31'd0, done}, 32'd1);
        check("R8 first operands kept", result, ref_div(32'h40490FDB, 32'h3FB504F3, 1'b1));

        // R9: result held while idle with changing inputs
        held = result;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            op_a = 32'h3F000000 + 32'(k * 977);
            op_b = 32'h41000000 - 32'(k * 311);
        end
        check("R9 result held", result, held);

        // Sweep over fraction and exponent pairs (R2, R3, R4, R5, R6)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                run_div({1'b0, 8'(96 + i * 3), mant(i)},
                        {1'b0, 8'(100 + j * 5), mant(j)}, "R4 sweep");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule